// File: doc/BRIEF.md
# Pseudo-Differential TMDS Lane Serialiser

This block turns a stream of 32-bit words into a serial bit stream for one video lane. Each word holds one or two 10-bit line-code symbols: the low symbol in bits 9:0 and, in two-symbol mode, a second in bits 19:10. Bits leave one per clock, lowest first, on a pin pair that the block drives in complementary form, so plain single-ended pins can imitate a differential pair. A companion output drives a complementary pixel-clock pair whose period is one symbol (ten clocks), phased so that its rising edge marks the first bit of every symbol.

When the word source runs dry in line-code mode, the lane repeats its last symbol and raises a sticky underflow flag. A debug mode turns the lane into an asynchronous serial transmitter on pin 0: a low start bit, the ten symbol bits and a high stop bit per word. An empty source stretches the stop bit. One enable starts and stops the data lane and the clock pair together.

Top module: `pdser_lane_tx`

## Requirements
- R1: In line-code mode each serial bit drives dat_pair to 2'b10 for a 0 and 2'b01 for a 1, and the ten bits of a symbol appear on ten consecutive clocks, bit 0 first.
- R2: When two_sym is 0 at acceptance, only bits 9:0 of a word are sent. When it is 1, bits 9:0 are sent and then bits 19:10. In line-code mode, word_ready is high only at a symbol boundary while no second symbol is held. A word is accepted when word_valid and word_ready are both high at a rising edge.
- R3: During reset and while en is low, dat_pair and clk_pair are 2'b10, word_ready is low, and words are not accepted.
- R4: In line-code mode, clk_pair[0] is high for 5 clocks and low for 5, and clk_pair[1] is its complement. Bit 0 of every symbol reaches dat_pair on the same clock that clk_pair[0] rises. The first symbol after en rises appears one clock after the first enabled edge.
- R5: At a line-code symbol boundary with no held symbol and word_valid low, the previous symbol is sent again (all zeros if none since reset). underflow is then set and stays set until reset.
- R6: In debug mode, a word accepted at a frame boundary produces, on the following 12 clocks, a start bit (dat_pair 2'b10), bits 9:0 lowest first, and a stop bit (2'b01). Bits 31:10 and two_sym are ignored, and clk_pair stays 2'b10.
- R7: In debug mode with no word offered at a frame boundary, dat_pair holds the stop level 2'b01 until a word arrives, and that word's start bit follows on the next clock.
- R8: Dropping en returns both pin pairs to 2'b10 on the next edge. The bits of the symbol in flight and any held second symbol are discarded. On re-enable, a new symbol starts with a rising clock edge.
- R9: dbg_mode is changed only while en is low. After a return to line-code mode, symbols resume with the previously sent symbol retained as the underflow fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the data lane and clock pair |
| dbg_mode | input | 1 | 1 selects the asynchronous serial debug framing |
| two_sym | input | 1 | 1 when each word carries two symbols |
| word_data | input | WORD_W | Word from the source FIFO |
| word_valid | input | 1 | Source has a word |
| word_ready | output | 1 | Lane takes the word at this edge |
| dat_pair | output | 2 | Complementary data pin pair |
| clk_pair | output | 2 | Complementary pixel-clock pin pair |
| underflow | output | 1 | Sticky: a symbol was repeated for lack of data |

## Verification
Both pin pairs are registered. Whatever the lane decides at a symbol or frame boundary shows up one clock later, and each following bit one clock after the one before it. word_ready is combinational and valid in the same cycle as the boundary. A behavioural model in the bench steps its own phase and symbol queue at every rising edge, and the outputs are compared at the following falling edge. This falls one register after the stimulus seen at that edge. New inputs change only after the comparison.

// File: rtl/pdser_pkg.sv
package pdser_pkg;
   localparam logic [1:0] PAIR_IDLE = 2'b10;

   function automatic logic [1:0] pin_pair(input logic bit_v);
      return {~bit_v, bit_v};
   endfunction
endpackage

// File: rtl/pdser_phase.sv
module pdser_phase #(
   parameter int SYM_W = 10,
   parameter int FRAME = 12,
   parameter int PH_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            dbg,
   input  logic            word_valid,
   output logic [PH_W-1:0] ph
);
   localparam logic [PH_W-1:0] LAST_T = PH_W'(SYM_W - 1);
   localparam logic [PH_W-1:0] LAST_D = PH_W'(FRAME - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (!en) begin
         ph <= '0;
      end else if (dbg) begin
         if (ph == '0 && !word_valid) ph <= '0;
         else if (ph == LAST_D)       ph <= '0;
         else                         ph <= ph + 1'b1;
      end else begin
         if (ph == LAST_T) ph <= '0;
         else              ph <= ph + 1'b1;
      end
   end

   a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !dbg) |-> (ph < PH_W'(SYM_W)));
endmodule

// File: rtl/pdser_clkgen.sv
module pdser_clkgen
   import pdser_pkg::*;
#(
   parameter int SYM_W = 10,
   parameter int PH_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            dbg,
   input  logic [PH_W-1:0] ph,
   output logic [1:0]      clk_pair
);
   localparam int HALF = SYM_W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          clk_pair <= PAIR_IDLE;
      else if (!en || dbg) clk_pair <= PAIR_IDLE;
      else                 clk_pair <= pin_pair(ph < PH_W'(HALF));
   end

   a_r4_clk_high_span: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !dbg && ph == PH_W'(HALF)) |-> (clk_pair == 2'b01));
endmodule

// File: rtl/pdser_lane.sv
module pdser_lane
   import pdser_pkg::*;
#(
   parameter int SYM_W   = 10,
   parameter int MAX_SPW = 2,
   parameter int FRAME   = 12,
   parameter int PH_W    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     dbg,
   input  logic                     two_sym,
   input  logic [SYM_W*MAX_SPW-1:0] word_data,
   input  logic                     word_valid,
   input  logic [PH_W-1:0]          ph,
   output logic                     word_ready,
   output logic [1:0]               dat_pair,
   output logic                     underflow
);
   localparam logic [PH_W-1:0] LAST_D = PH_W'(FRAME - 1);

   logic [SYM_W-1:0] cur_q, last_q, pend_q, nsym;
   logic             pv_q, at_edge, take;

   assign at_edge    = (ph == '0);
   assign word_ready = en && at_edge && (dbg || !pv_q);
   assign take       = word_ready && word_valid;

   always_comb begin
      if (pv_q)            nsym = pend_q;
      else if (word_valid) nsym = word_data[SYM_W-1:0];
      else                 nsym = last_q;
   end

   generate
      if (MAX_SPW > 1) begin : g_pend
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pv_q   <= 1'b0;
               pend_q <= '0;
            end else if (!en) begin
               pv_q <= 1'b0;
            end else if (!dbg && at_edge) begin
               if (pv_q) begin
                  pv_q <= 1'b0;
               end else if (take && two_sym) begin
                  pv_q   <= 1'b1;
                  pend_q <= word_data[2*SYM_W-1:SYM_W];
               end
            end
         end
      end else begin : g_single
         logic unused_two;
         assign unused_two = two_sym;
         assign pv_q       = 1'b0;
         assign pend_q     = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_pair  <= PAIR_IDLE;
         cur_q     <= '0;
         last_q    <= '0;
         underflow <= 1'b0;
      end else if (!en) begin
         dat_pair <= PAIR_IDLE;
      end else if (dbg) begin
         if (at_edge) begin
            if (word_valid) begin
               cur_q    <= word_data[SYM_W-1:0];
               dat_pair <= pin_pair(1'b0);
            end else begin
               dat_pair <= pin_pair(1'b1);
            end
         end else if (ph == LAST_D) begin
            dat_pair <= pin_pair(1'b1);
         end else begin
            dat_pair <= pin_pair(cur_q[0]);
            cur_q    <= cur_q >> 1;
         end
      end else begin
         if (at_edge) begin
            dat_pair <= pin_pair(nsym[0]);
            cur_q    <= nsym >> 1;
            last_q   <= nsym;
            if (!pv_q && !word_valid) underflow <= 1'b1;
         end else begin
            dat_pair <= pin_pair(cur_q[0]);
            cur_q    <= cur_q >> 1;
         end
      end
   end

   a_r2_ready_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      word_ready |-> (en && ph == '0));
   a_r5_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);
   a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && dbg && ph == '0 && !word_valid) |=> (dat_pair == 2'b01));
   a_r6_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (en && dbg && ph == '0 && word_valid) |=> (dat_pair == 2'b10));
endmodule

// File: rtl/pdser_lane_tx.sv
module pdser_lane_tx #(
   parameter int SYM_W   = 10,
   parameter int WORD_W  = 32,
   parameter int MAX_SPW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              dbg_mode,
   input  logic              two_sym,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_valid,
   output logic              word_ready,
   output logic [1:0]        dat_pair,
   output logic [1:0]        clk_pair,
   output logic              underflow
);
   localparam int FRAME  = SYM_W + 2;
   localparam int PH_W   = $clog2(FRAME);
   localparam int USED_W = SYM_W * MAX_SPW;

   generate
      if (MAX_SPW < 1 || MAX_SPW > 2) begin : g_bad_spw
         $error("MAX_SPW must be 1 or 2");
      end
      if (USED_W > WORD_W) begin : g_bad_word
         $error("symbols do not fit in a word");
      end
      if (SYM_W % 2 != 0) begin : g_bad_sym
         $error("SYM_W must be even for a 50 percent clock");
      end
      if (WORD_W > USED_W) begin : g_spare
         logic unused_upper;
         assign unused_upper = ^word_data[WORD_W-1:USED_W];
      end
   endgenerate

   logic [PH_W-1:0] ph;

   pdser_phase #(.SYM_W(SYM_W), .FRAME(FRAME), .PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .en(en), .dbg(dbg_mode),
      .word_valid(word_valid), .ph(ph));

   pdser_clkgen #(.SYM_W(SYM_W), .PH_W(PH_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(en), .dbg(dbg_mode),
      .ph(ph), .clk_pair(clk_pair));

   pdser_lane #(.SYM_W(SYM_W), .MAX_SPW(MAX_SPW), .FRAME(FRAME), .PH_W(PH_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en), .dbg(dbg_mode), .two_sym(two_sym),
      .word_data(word_data[USED_W-1:0]), .word_valid(word_valid), .ph(ph),
      .word_ready(word_ready), .dat_pair(dat_pair), .underflow(underflow));

   a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (dat_pair == 2'b10 && clk_pair == 2'b10));
   a_r4_rise_marks_symbol: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_pair[0]) |-> ($past(ph) == '0 && $past(en) && !$past(dbg_mode)));
endmodule

// File: tb/test_pdser_lane_tx.sv
module test_pdser_lane_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, dbg_mode = 1'b0, two_sym = 1'b0;
   logic [31:0] word_data = '0;
   logic        word_valid = 1'b0;
   logic        word_ready, underflow;
   logic [1:0]  dat_pair, clk_pair;

   int vectors = 0, errors = 0;
   bit cmp_on = 0, feed_on = 0, done = 0;
   string cur_req = "R3";

   logic [31:0] wq[$];
   logic [9:0]  symq[$];
   int          mph = 0;
   logic [9:0]  mbits = '0, mlast = '0;
   logic [1:0]  mdat = 2'b10, mclk = 2'b10;
   logic        muf = 1'b0;

   always #10 clk = ~clk;

   pdser_lane_tx i_pdser_lane_tx (
      .clk(clk), .rst_n(rst_n), .en(en), .dbg_mode(dbg_mode), .two_sym(two_sym),
      .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
      .dat_pair(dat_pair), .clk_pair(clk_pair), .underflow(underflow));

   function automatic logic [1:0] enc(input logic b);
      return b ? 2'b01 : 2'b10;
   endfunction

   function automatic logic exp_ready();
      return en && mph == 0 && (dbg_mode || symq.size() == 0);
   endfunction

   // behavioural reference, stepped at every rising edge
   always @(posedge clk) begin
      logic [31:0] w;
      logic [9:0]  s;
      logic        acc;
      acc = exp_ready() && word_valid;
      if (!rst_n) begin
         mph = 0; mbits = '0; mlast = '0; mdat = 2'b10; mclk = 2'b10; muf = 0;
         symq.delete();
      end else if (!en) begin
         mdat = 2'b10; mclk = 2'b10; mph = 0; symq.delete();
      end else if (dbg_mode) begin
         mclk = 2'b10;
         if (mph == 0) begin
            if (acc) begin
               w = wq.pop_front(); mbits = w[9:0]; mdat = 2'b10; mph = 1;
            end else mdat = 2'b01;
         end else if (mph == 11) begin
            mdat = 2'b01; mph = 0;
         end else begin
            mdat = enc(mbits[mph-1]); mph = mph + 1;
         end
      end else begin
         mclk = (mph < 5) ? 2'b01 : 2'b10;
         if (mph == 0) begin
            if (symq.size() > 0) s = symq.pop_front();
            else if (acc) begin
               w = wq.pop_front(); s = w[9:0];
               if (two_sym) symq.push_back(w[19:10]);
            end else begin
               s = mlast; muf = 1'b1;
            end
            mlast = s; mbits = s;
         end
         mdat = enc(mbits[mph]);
         mph = (mph + 1) % 10;
      end
   end

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s) t=%0t actual=%b expected=%b", tag, cur_req, $time, act, exp);
      end
   endtask

   task automatic compare();
      if (!cmp_on) return;
      chk("R1 dat_pair", dat_pair, mdat);
      chk("R4 clk_pair", clk_pair, mclk);
      chk("R2 word_ready", {1'b0, word_ready}, {1'b0, exp_ready()});
      chk("R5 underflow", {1'b0, underflow}, {1'b0, muf});
   endtask

   task automatic drive_feed();
      word_valid = feed_on && wq.size() > 0;
      word_data  = (wq.size() > 0) ? wq[0] : 32'h0;
   endtask

   task automatic step(input int n);
      repeat (n) begin
         drive_feed();
         @(negedge clk);
         compare();
      end
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      // R3: reset state
      @(posedge clk); cmp_on = 1;
      step(3);
      rst_n = 1'b1;
      step(2);
      // R3: disabled lane refuses words
      feed_on = 1; wq.push_back(32'h0000_02A5); wq.push_back(32'h0000_0133);
      step(20);
      // R1 R2 R4: one symbol per word, upper bits ignored
      cur_req = "R1";
      wq.push_back(32'hFFFF_F3FF); wq.push_back(32'hABCD_E000);
      wq.push_back(32'h0000_0155); wq.push_back(32'h0000_02AA);
      wq.push_back(32'h5550_00F3); wq.push_back(32'h0000_0201);
      en = 1'b1;
      step(45);
      // R2: two symbols per word
      cur_req = "R2"; two_sym = 1'b1;
      wq.push_back(32'h000F_FC00); wq.push_back(32'h0005_4AB3);
      wq.push_back(32'hFFF8_0001); wq.push_back(32'h0000_03FF);
      step(90);
      // R5: starvation repeats last symbol and sets sticky flag
      cur_req = "R5"; feed_on = 0;
      wq.push_back(32'h0003_C0F1);
      step(35);
      feed_on = 1;
      step(30);
      // R8: drop enable in the middle of a symbol pair
      cur_req = "R8";
      wq.push_back(32'h0006_6199); wq.push_back(32'h0001_8E07);
      step(13);
      en = 1'b0; step(5);
      en = 1'b1; step(40);
      // R6 R7: debug framing, gaps hold the stop level
      cur_req = "R6";
      en = 1'b0; step(2);
      dbg_mode = 1'b1; step(2);
      wq.push_back(32'hFFFF_FD5A); wq.push_back(32'h0000_0001); wq.push_back(32'h0000_0200);
      en = 1'b1; step(45);
      cur_req = "R7"; feed_on = 0;
      wq.push_back(32'h0000_0317);
      step(17);
      feed_on = 1; step(20);
      // R9: back to line-code mode
      cur_req = "R9";
      en = 1'b0; step(3);
      dbg_mode = 1'b0; two_sym = 1'b0; step(1);
      wq.push_back(32'h0000_00C6);
      en = 1'b1; step(40);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule